// File: doc/BRIEF.md
# Virtual-Link Flow Classifier and Router

This block sorts received frames into flows and decides where each one goes. Every frame header that arrives is reduced to a lookup key made of three fields: destination MAC address, VLAN ID and VLAN priority (PCP). The key is compared in parallel against a table of flow entries that a host loads through a simple write port. When an entry matches, its routing actions are applied. The actions are drop, trap to the CPU, and redirect to a mask of egress ports. Trap and redirect may be combined, and the frame then goes to both. When no entry matches, the frame is marked as unmatched and is left to the ordinary forwarding logic.

The key always has all three fields. For an ingress port that is not VLAN-aware, the VID and PCP carried by the frame are ignored. The VID is then filled in from the port's state: a per-port value while the port stands alone, or one shared value while it belongs to a VLAN-unaware bridge. The PCP is set to a fixed value. In that mode only the destination address really selects the entry. Each entry also carries a time-critical flag, which tells the buffer manager to draw from its reserved partition, and a saturating count of the frames it dropped.

Top module: `flowcls_router`

## Requirements
- R1: For a VLAN-aware ingress port the lookup key is the frame's DA, VID and PCP, and an entry matches only when all three are equal to the stored values.
- R2: For a VLAN-unaware ingress port the frame's VID and PCP are ignored. The key VID is SA_VID_BASE plus the port number when the port stands alone (port_in_bridge=0), or BR_VID when port_in_bridge=1. The key PCP is UNAWARE_PCP (default 0). Defaults: SA_VID_BASE=0xFF0, BR_VID=0xFE0.
- R3: A matched entry whose drop action is set gives dec_drop=1, dec_to_cpu=0 and dec_port_mask=0, whatever its other actions are.
- R4: Without drop, the trap action sets dec_to_cpu and the redirect action copies the entry's port mask to dec_port_mask. Both together give the union of the two.
- R5: A matched entry that leaves a frame with no destination (no CPU and a zero port mask) gives dec_drop=1.
- R6: When several valid entries match, the lowest index wins, and dec_idx reports that index.
- R7: A frame that matches no valid entry gives dec_match=0 with the mask, CPU, drop and critical outputs all 0.
- R8: dec_crit reports the time-critical flag of the matched entry.
- R9: The decision is registered. dec_valid is frm_valid delayed by one clock, and all decision fields are 0 in cycles where dec_valid is 0.
- R10: Each dropped frame adds one to its entry's counter in drop_cnt (entry e occupies bits e*CNT_W and up). The counter saturates at its all-ones value.
- R11: A write with wr_valid=1 loads entry wr_addr and clears that entry's drop counter in the same cycle. Writing wr_entry_en=0 removes the entry from lookup.
- R12: After reset every entry is invalid, every counter is 0 and dec_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frm_valid | input | 1 | A parsed frame header is present this cycle |
| frm_da | input | 48 | Destination MAC address |
| frm_vid | input | 12 | VLAN ID taken from the frame |
| frm_pcp | input | 3 | VLAN priority taken from the frame |
| frm_port | input | PORT_W | Ingress port number |
| port_vlan_aware | input | NUM_PORTS | Per-port VLAN-awareness |
| port_in_bridge | input | NUM_PORTS | Per-port: 1 = in a bridge, 0 = standalone |
| wr_valid | input | 1 | Table write strobe |
| wr_addr | input | IDX_W | Entry index to write |
| wr_entry_en | input | 1 | Entry takes part in lookup |
| wr_da | input | 48 | Entry key: DA |
| wr_vid | input | 12 | Entry key: VID |
| wr_pcp | input | 3 | Entry key: PCP |
| wr_act_drop | input | 1 | Drop action |
| wr_act_trap | input | 1 | Trap-to-CPU action |
| wr_act_redir | input | 1 | Redirect action |
| wr_crit | input | 1 | Time-critical entry |
| wr_port_mask | input | NUM_PORTS | Redirect destination ports |
| dec_valid | output | 1 | Decision present |
| dec_match | output | 1 | An entry matched |
| dec_idx | output | IDX_W | Index of the winning entry |
| dec_port_mask | output | NUM_PORTS | Egress ports |
| dec_to_cpu | output | 1 | Deliver to the CPU |
| dec_drop | output | 1 | Discard the frame |
| dec_crit | output | 1 | Use the reserved buffer partition |
| drop_cnt | output | NUM_ENTRIES*CNT_W | Drop counters, one per entry |

## Verification
The assertions check on every cycle the properties of the decision itself. A drop never carries destinations. An unmatched or idle decision is all zero. A match that leaves no destination is a drop. The critical flag appears only together with a match. dec_valid tracks frm_valid one cycle later. A written entry's counter reads zero on the following cycle. Only the bench scenarios can show the behaviour that depends on table contents: which fields take part in the key for aware and unaware ports, the lowest-index priority among overlapping entries, the union of trap and redirect, counting up to saturation, and the effect of rewriting or removing an entry.

// File: rtl/flowcls_pkg.sv
package flowcls_pkg;
   localparam int DA_W  = 48;
   localparam int VID_W = 12;
   localparam int PCP_W = 3;

   typedef struct packed {
      logic [DA_W-1:0]  da;
      logic [VID_W-1:0] vid;
      logic [PCP_W-1:0] pcp;
   } flow_key_t;

   typedef struct packed {
      logic act_drop;
      logic act_trap;
      logic act_redir;
      logic crit;
   } flow_act_t;

   function automatic logic key_equal(flow_key_t a, flow_key_t b);
      return (a.da == b.da) && (a.vid == b.vid) && (a.pcp == b.pcp);
   endfunction
endpackage

// File: rtl/flowcls_keygen.sv
module flowcls_keygen
   import flowcls_pkg::*;
#(
   parameter int NUM_PORTS = 5,
   parameter int PORT_W = 3,
   parameter logic [VID_W-1:0] SA_VID_BASE = 12'hFF0,
   parameter logic [VID_W-1:0] BR_VID = 12'hFE0,
   parameter logic [PCP_W-1:0] UNAWARE_PCP = 3'd0
) (
   input  logic [DA_W-1:0]      da_i,
   input  logic [VID_W-1:0]     vid_i,
   input  logic [PCP_W-1:0]     pcp_i,
   input  logic [PORT_W-1:0]    port_i,
   input  logic [NUM_PORTS-1:0] aware_i,
   input  logic [NUM_PORTS-1:0] bridged_i,
   output flow_key_t            key_o
);
   logic             port_ok;
   logic             aware;
   logic             bridged;
   logic [VID_W-1:0] sa_vid;

   always_comb begin
      port_ok = int'(port_i) < NUM_PORTS;
      aware   = 1'b1;
      bridged = 1'b0;
      for (int p = 0; p < NUM_PORTS; p++) begin
         if (port_ok && int'(port_i) == p) begin
            aware   = aware_i[p];
            bridged = bridged_i[p];
         end
      end
      sa_vid = SA_VID_BASE + VID_W'(port_i);
      key_o.da = da_i;
      if (aware) begin
         key_o.vid = vid_i;
         key_o.pcp = pcp_i;
      end else begin
         key_o.vid = bridged ? BR_VID : sa_vid;
         key_o.pcp = UNAWARE_PCP;
      end
   end
endmodule

// File: rtl/flowcls_table.sv
module flowcls_table
   import flowcls_pkg::*;
#(
   parameter int NUM_ENTRIES = 16,
   parameter int NUM_PORTS = 5,
   parameter int IDX_W = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_valid,
   input  logic [IDX_W-1:0]     wr_addr,
   input  logic                 wr_en,
   input  flow_key_t            wr_key,
   input  flow_act_t            wr_act,
   input  logic [NUM_PORTS-1:0] wr_mask,
   input  flow_key_t            key_i,
   output logic                 hit_o,
   output logic [IDX_W-1:0]     hit_idx_o,
   output flow_act_t            hit_act_o,
   output logic [NUM_PORTS-1:0] hit_mask_o
);
   logic [NUM_ENTRIES-1:0] ent_vld;
   logic [NUM_ENTRIES-1:0] hit_vec;
   flow_key_t              ent_key  [NUM_ENTRIES];
   flow_act_t              ent_act  [NUM_ENTRIES];
   logic [NUM_PORTS-1:0]   ent_mask [NUM_ENTRIES];

   for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_ent
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ent_vld[e]  <= 1'b0;
            ent_key[e]  <= '0;
            ent_act[e]  <= '0;
            ent_mask[e] <= '0;
         end else if (wr_valid && int'(wr_addr) == e) begin
            ent_vld[e]  <= wr_en;
            ent_key[e]  <= wr_key;
            ent_act[e]  <= wr_act;
            ent_mask[e] <= wr_mask;
         end
      end
      assign hit_vec[e] = ent_vld[e] && key_equal(ent_key[e], key_i);
   end

   // lowest index has priority: scan downwards so the last assignment wins
   always_comb begin
      hit_idx_o = '0;
      for (int e = NUM_ENTRIES - 1; e >= 0; e--) begin
         if (hit_vec[e]) hit_idx_o = IDX_W'(e);
      end
      hit_o      = |hit_vec;
      hit_act_o  = ent_act[hit_idx_o];
      hit_mask_o = ent_mask[hit_idx_o];
   end
endmodule

// File: rtl/flowcls_action.sv
module flowcls_action
   import flowcls_pkg::*;
#(
   parameter int NUM_PORTS = 5
) (
   input  logic                 hit_i,
   input  flow_act_t            act_i,
   input  logic [NUM_PORTS-1:0] mask_i,
   output logic [NUM_PORTS-1:0] mask_o,
   output logic                 cpu_o,
   output logic                 drop_o,
   output logic                 crit_o
);
   logic [NUM_PORTS-1:0] redir_ports;
   logic                 no_dest;

   always_comb begin
      redir_ports = act_i.act_redir ? mask_i : '0;
      no_dest     = !act_i.act_trap && (redir_ports == '0);
      if (!hit_i) begin
         mask_o = '0;
         cpu_o  = 1'b0;
         drop_o = 1'b0;
         crit_o = 1'b0;
      end else if (act_i.act_drop || no_dest) begin
         mask_o = '0;
         cpu_o  = 1'b0;
         drop_o = 1'b1;
         crit_o = act_i.crit;
      end else begin
         mask_o = redir_ports;
         cpu_o  = act_i.act_trap;
         drop_o = 1'b0;
         crit_o = act_i.crit;
      end
   end
endmodule

// File: rtl/flowcls_drop_ctr.sv
module flowcls_drop_ctr #(
   parameter int NUM_ENTRIES = 16,
   parameter int CNT_W = 16,
   parameter int IDX_W = 4
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         inc_i,
   input  logic [IDX_W-1:0]             inc_idx_i,
   input  logic                         clr_i,
   input  logic [IDX_W-1:0]             clr_idx_i,
   output logic [NUM_ENTRIES*CNT_W-1:0] cnt_o
);
   for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_cnt
      logic [CNT_W-1:0] cnt;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cnt <= '0;
         end else if (clr_i && int'(clr_idx_i) == e) begin
            cnt <= '0;
         end else if (inc_i && int'(inc_idx_i) == e && cnt != '1) begin
            cnt <= cnt + 1'b1;
         end
      end
      assign cnt_o[e*CNT_W +: CNT_W] = cnt;
   end
endmodule

// File: rtl/flowcls_router.sv
module flowcls_router
   import flowcls_pkg::*;
#(
   parameter int NUM_ENTRIES = 16,
   parameter int NUM_PORTS = 5,
   parameter int CNT_W = 16,
   parameter logic [11:0] SA_VID_BASE = 12'hFF0,
   parameter logic [11:0] BR_VID = 12'hFE0,
   parameter logic [2:0] UNAWARE_PCP = 3'd0,
   localparam int PORT_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
   localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         frm_valid,
   input  logic [47:0]                  frm_da,
   input  logic [11:0]                  frm_vid,
   input  logic [2:0]                   frm_pcp,
   input  logic [PORT_W-1:0]            frm_port,
   input  logic [NUM_PORTS-1:0]         port_vlan_aware,
   input  logic [NUM_PORTS-1:0]         port_in_bridge,
   input  logic                         wr_valid,
   input  logic [IDX_W-1:0]             wr_addr,
   input  logic                         wr_entry_en,
   input  logic [47:0]                  wr_da,
   input  logic [11:0]                  wr_vid,
   input  logic [2:0]                   wr_pcp,
   input  logic                         wr_act_drop,
   input  logic                         wr_act_trap,
   input  logic                         wr_act_redir,
   input  logic                         wr_crit,
   input  logic [NUM_PORTS-1:0]         wr_port_mask,
   output logic                         dec_valid,
   output logic                         dec_match,
   output logic [IDX_W-1:0]             dec_idx,
   output logic [NUM_PORTS-1:0]         dec_port_mask,
   output logic                         dec_to_cpu,
   output logic                         dec_drop,
   output logic                         dec_crit,
   output logic [NUM_ENTRIES*CNT_W-1:0] drop_cnt
);
   if (NUM_ENTRIES < 1 || NUM_ENTRIES > 1024) begin : g_bad_entries
      $error("flowcls_router: NUM_ENTRIES must lie in 1..1024");
   end
   if (NUM_PORTS < 2 || NUM_PORTS > 16) begin : g_bad_ports
      $error("flowcls_router: NUM_PORTS must lie in 2..16");
   end
   if (CNT_W < 2 || CNT_W > 32) begin : g_bad_cnt
      $error("flowcls_router: CNT_W must lie in 2..32");
   end
   if (int'(SA_VID_BASE) + NUM_PORTS > 4096) begin : g_bad_vid
      $error("flowcls_router: standalone VID range exceeds 12 bits");
   end

   flow_key_t            look_key;
   flow_key_t            wr_key;
   flow_act_t            wr_act;
   logic                 hit;
   logic [IDX_W-1:0]     hit_idx;
   flow_act_t            hit_act;
   logic [NUM_PORTS-1:0] hit_mask;
   logic [NUM_PORTS-1:0] nx_mask;
   logic                 nx_cpu;
   logic                 nx_drop;
   logic                 nx_crit;

   assign wr_key = '{da: wr_da, vid: wr_vid, pcp: wr_pcp};
   assign wr_act = '{act_drop: wr_act_drop, act_trap: wr_act_trap,
                     act_redir: wr_act_redir, crit: wr_crit};

   flowcls_keygen #(
      .NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W), .SA_VID_BASE(SA_VID_BASE),
      .BR_VID(BR_VID), .UNAWARE_PCP(UNAWARE_PCP)
   ) u_keygen (
      .da_i(frm_da), .vid_i(frm_vid), .pcp_i(frm_pcp), .port_i(frm_port),
      .aware_i(port_vlan_aware), .bridged_i(port_in_bridge), .key_o(look_key)
   );

   flowcls_table #(
      .NUM_ENTRIES(NUM_ENTRIES), .NUM_PORTS(NUM_PORTS), .IDX_W(IDX_W)
   ) u_table (
      .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
      .wr_en(wr_entry_en), .wr_key(wr_key), .wr_act(wr_act),
      .wr_mask(wr_port_mask), .key_i(look_key), .hit_o(hit),
      .hit_idx_o(hit_idx), .hit_act_o(hit_act), .hit_mask_o(hit_mask)
   );

   flowcls_action #(
      .NUM_PORTS(NUM_PORTS)
   ) u_action (
      .hit_i(hit), .act_i(hit_act), .mask_i(hit_mask), .mask_o(nx_mask),
      .cpu_o(nx_cpu), .drop_o(nx_drop), .crit_o(nx_crit)
   );

   flowcls_drop_ctr #(
      .NUM_ENTRIES(NUM_ENTRIES), .CNT_W(CNT_W), .IDX_W(IDX_W)
   ) u_ctr (
      .clk(clk), .rst_n(rst_n), .inc_i(frm_valid && nx_drop),
      .inc_idx_i(hit_idx), .clr_i(wr_valid), .clr_idx_i(wr_addr),
      .cnt_o(drop_cnt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dec_valid     <= 1'b0;
         dec_match     <= 1'b0;
         dec_idx       <= '0;
         dec_port_mask <= '0;
         dec_to_cpu    <= 1'b0;
         dec_drop      <= 1'b0;
         dec_crit      <= 1'b0;
      end else begin
         dec_valid     <= frm_valid;
         dec_match     <= frm_valid && hit;
         dec_idx       <= (frm_valid && hit) ? hit_idx : '0;
         dec_port_mask <= frm_valid ? nx_mask : '0;
         dec_to_cpu    <= frm_valid && nx_cpu;
         dec_drop      <= frm_valid && nx_drop;
         dec_crit      <= frm_valid && nx_crit;
      end
   end
endmodule

// File: rtl/flowcls_router_chk.sv
module flowcls_router_chk #(
   parameter int NUM_ENTRIES = 16,
   parameter int NUM_PORTS = 5,
   parameter int CNT_W = 16,
   parameter int IDX_W = 4
) (
   input logic                         clk,
   input logic                         rst_n,
   input logic                         frm_valid,
   input logic                         wr_valid,
   input logic [IDX_W-1:0]             wr_addr,
   input logic                         dec_valid,
   input logic                         dec_match,
   input logic [IDX_W-1:0]             dec_idx,
   input logic [NUM_PORTS-1:0]         dec_port_mask,
   input logic                         dec_to_cpu,
   input logic                         dec_drop,
   input logic                         dec_crit,
   input logic [NUM_ENTRIES*CNT_W-1:0] drop_cnt
);
   logic             seen;
   logic             wr_q;
   logic [IDX_W-1:0] wr_addr_q;
   logic [CNT_W-1:0] cnt_at_wr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen      <= 1'b0;
         wr_q      <= 1'b0;
         wr_addr_q <= '0;
      end else begin
         seen      <= 1'b1;
         wr_q      <= wr_valid && int'(wr_addr) < NUM_ENTRIES;
         wr_addr_q <= wr_addr;
      end
   end

   always_comb begin
      cnt_at_wr = '0;
      for (int e = 0; e < NUM_ENTRIES; e++) begin
         if (int'(wr_addr_q) == e) cnt_at_wr = drop_cnt[e*CNT_W +: CNT_W];
      end
   end

   assert_valid_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
      seen |-> dec_valid == $past(frm_valid));
   assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !dec_valid |-> !dec_match && !dec_drop && !dec_to_cpu && dec_port_mask == '0);
   assert_drop_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
      dec_drop |-> !dec_to_cpu && dec_port_mask == '0);
   assert_nodest_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_match && !dec_to_cpu && dec_port_mask == '0) |-> dec_drop);
   assert_nomatch_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_valid && !dec_match) |-> !dec_drop && !dec_to_cpu && !dec_crit
                                    && dec_port_mask == '0);
   assert_crit_needs_hit_R8: assert property (@(posedge clk) disable iff (!rst_n)
      dec_crit |-> dec_match);
   assert_idx_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
      dec_match |-> int'(dec_idx) < NUM_ENTRIES);
   assert_wr_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
      wr_q |-> cnt_at_wr == '0);
endmodule

bind flowcls_router flowcls_router_chk #(
   .NUM_ENTRIES(NUM_ENTRIES), .NUM_PORTS(NUM_PORTS), .CNT_W(CNT_W), .IDX_W(IDX_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .wr_valid(wr_valid),
   .wr_addr(wr_addr), .dec_valid(dec_valid), .dec_match(dec_match),
   .dec_idx(dec_idx), .dec_port_mask(dec_port_mask), .dec_to_cpu(dec_to_cpu),
   .dec_drop(dec_drop), .dec_crit(dec_crit), .drop_cnt(drop_cnt)
);

// File: tb/flowcls_router_tb.sv
module flowcls_router_tb;
   localparam int NE = 16;
   localparam int NP = 5;
   localparam int CW = 16;

   localparam logic [47:0] DA_A = 48'h02_00_00_00_00_0A;
   localparam logic [47:0] DA_B = 48'h02_00_00_00_00_0B;
   localparam logic [47:0] DA_C = 48'h02_00_00_00_00_0C;
   localparam logic [47:0] DA_D = 48'h02_00_00_00_00_0D;
   localparam logic [47:0] DA_E = 48'h02_00_00_00_00_0E;
   localparam logic [47:0] DA_F = 48'h02_00_00_00_00_0F;
   localparam logic [47:0] DA_G = 48'h02_00_00_00_00_10;
   localparam logic [47:0] DA_X = 48'h02_00_00_00_00_99;

   typedef struct packed {
      logic [2:0]  port;
      logic        aware;
      logic        bridged;
      logic [47:0] da;
      logic [11:0] vid;
      logic [2:0]  pcp;
      logic        m;
      logic [3:0]  idx;
      logic [4:0]  mask;
      logic        cpu;
      logic        drop;
      logic        crit;
   } vec_t;

   localparam vec_t VEC [13] = '{
      '{3'd0, 1'b1, 1'b0, DA_A, 12'd100, 3'd0, 1'b1, 4'd0, 5'b00000, 1'b0, 1'b1, 1'b0},
      '{3'd1, 1'b1, 1'b0, DA_B, 12'd100, 3'd3, 1'b1, 4'd1, 5'b00000, 1'b1, 1'b0, 1'b0},
      '{3'd1, 1'b1, 1'b0, DA_B, 12'd100, 3'd2, 1'b0, 4'd0, 5'b00000, 1'b0, 1'b0, 1'b0},
      '{3'd1, 1'b1, 1'b0, DA_B, 12'd101, 3'd3, 1'b0, 4'd0, 5'b00000, 1'b0, 1'b0, 1'b0},
      '{3'd0, 1'b1, 1'b0, DA_C, 12'd200, 3'd5, 1'b1, 4'd3, 5'b01000, 1'b1, 1'b0, 1'b1},
      '{3'd2, 1'b0, 1'b0, DA_D, 12'd55,  3'd6, 1'b1, 4'd4, 5'b00010, 1'b0, 1'b0, 1'b0},
      '{3'd3, 1'b0, 1'b0, DA_D, 12'd55,  3'd6, 1'b0, 4'd0, 5'b00000, 1'b0, 1'b0, 1'b0},
      '{3'd3, 1'b0, 1'b1, DA_D, 12'd0,   3'd4, 1'b1, 4'd5, 5'b00000, 1'b1, 1'b0, 1'b1},
      '{3'd0, 1'b1, 1'b0, DA_D, 12'hFE0, 3'd0, 1'b1, 4'd5, 5'b00000, 1'b1, 1'b0, 1'b1},
      '{3'd0, 1'b1, 1'b0, DA_E, 12'd10,  3'd1, 1'b1, 4'd6, 5'b00000, 1'b0, 1'b1, 1'b0},
      '{3'd0, 1'b1, 1'b0, DA_F, 12'd10,  3'd1, 1'b1, 4'd7, 5'b00000, 1'b0, 1'b1, 1'b0},
      '{3'd4, 1'b1, 1'b0, DA_G, 12'd7,   3'd7, 1'b1, 4'd9, 5'b00000, 1'b0, 1'b1, 1'b0},
      '{3'd0, 1'b1, 1'b0, DA_X, 12'd100, 3'd0, 1'b0, 4'd0, 5'b00000, 1'b0, 1'b0, 1'b0}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic frm_valid = 1'b0;
   logic [47:0] frm_da = '0;
   logic [11:0] frm_vid = '0;
   logic [2:0] frm_pcp = '0;
   logic [2:0] frm_port = '0;
   logic [NP-1:0] port_vlan_aware = '1;
   logic [NP-1:0] port_in_bridge = '0;
   logic wr_valid = 1'b0;
   logic [3:0] wr_addr = '0;
   logic wr_entry_en = 1'b0;
   logic [47:0] wr_da = '0;
   logic [11:0] wr_vid = '0;
   logic [2:0] wr_pcp = '0;
   logic wr_act_drop = 1'b0;
   logic wr_act_trap = 1'b0;
   logic wr_act_redir = 1'b0;
   logic wr_crit = 1'b0;
   logic [NP-1:0] wr_port_mask = '0;
   logic dec_valid, dec_match, dec_to_cpu, dec_drop, dec_crit;
   logic [3:0] dec_idx;
   logic [NP-1:0] dec_port_mask;
   logic [NE*CW-1:0] drop_cnt;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   flowcls_router u_dut (
      .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .frm_da(frm_da),
      .frm_vid(frm_vid), .frm_pcp(frm_pcp), .frm_port(frm_port),
      .port_vlan_aware(port_vlan_aware), .port_in_bridge(port_in_bridge),
      .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_entry_en(wr_entry_en),
      .wr_da(wr_da), .wr_vid(wr_vid), .wr_pcp(wr_pcp),
      .wr_act_drop(wr_act_drop), .wr_act_trap(wr_act_trap),
      .wr_act_redir(wr_act_redir), .wr_crit(wr_crit),
      .wr_port_mask(wr_port_mask), .dec_valid(dec_valid),
      .dec_match(dec_match), .dec_idx(dec_idx), .dec_port_mask(dec_port_mask),
      .dec_to_cpu(dec_to_cpu), .dec_drop(dec_drop), .dec_crit(dec_crit),
      .drop_cnt(drop_cnt)
   );

   task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [CW-1:0] cnt_of(int e);
      return drop_cnt[e*CW +: CW];
   endfunction

   task automatic load(int a, bit en, logic [47:0] da, logic [11:0] vid,
                       logic [2:0] pcp, bit d, bit t, bit r, bit c, logic [4:0] m);
      @(negedge clk);
      wr_valid = 1'b1; wr_addr = 4'(a); wr_entry_en = en;
      wr_da = da; wr_vid = vid; wr_pcp = pcp;
      wr_act_drop = d; wr_act_trap = t; wr_act_redir = r; wr_crit = c;
      wr_port_mask = m;
      @(negedge clk);
      wr_valid = 1'b0;
   endtask

   // frame presented for one cycle; decision is visible at the following negedge
   task automatic send(logic [2:0] port, bit aware, bit bridged,
                       logic [47:0] da, logic [11:0] vid, logic [2:0] pcp);
      @(negedge clk);
      frm_port = port; frm_da = da; frm_vid = vid; frm_pcp = pcp;
      port_vlan_aware = aware ? '1 : '0;
      port_in_bridge  = bridged ? '1 : '0;
      frm_valid = 1'b1;
      @(negedge clk);
      frm_valid = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      // R12 reset state
      repeat (3) @(negedge clk);
      chk("R12 dec_valid in reset", 64'(dec_valid), 64'd0);
      chk("R12 counters in reset", 64'(drop_cnt == '0), 64'd1);
      rst_n = 1'b1;
      send(3'd0, 1'b1, 1'b0, DA_A, 12'd100, 3'd0);
      chk("R12 empty table no match", 64'(dec_match), 64'd0);
      chk("R9 dec_valid after frame", 64'(dec_valid), 64'd1);

      load(0, 1, DA_A, 12'd100, 3'd0, 1, 0, 0, 0, 5'b00000);
      load(1, 1, DA_B, 12'd100, 3'd3, 0, 1, 0, 0, 5'b00000);
      load(2, 1, DA_B, 12'd100, 3'd3, 0, 0, 1, 0, 5'b01000);
      load(3, 1, DA_C, 12'd200, 3'd5, 0, 1, 1, 1, 5'b01000);
      load(4, 1, DA_D, 12'hFF2, 3'd0, 0, 0, 1, 0, 5'b00010);
      load(5, 1, DA_D, 12'hFE0, 3'd0, 0, 1, 0, 1, 5'b00000);
      load(6, 1, DA_E, 12'd10, 3'd1, 0, 0, 1, 0, 5'b00000);
      load(7, 1, DA_F, 12'd10, 3'd1, 0, 0, 0, 0, 5'b00000);
      load(8, 1, DA_A, 12'd100, 3'd0, 0, 1, 0, 0, 5'b00000);
      load(9, 1, DA_G, 12'd7, 3'd7, 1, 1, 1, 0, 5'b11111);

      // vector walk: R1 exact key, R2 unaware key, R3 drop, R4 union,
      // R5 no destination, R6 priority, R7 no match, R8 critical flag
      for (int i = 0; i < 13; i++) begin
         send(VEC[i].port, VEC[i].aware, VEC[i].bridged, VEC[i].da,
              VEC[i].vid, VEC[i].pcp);
         chk($sformatf("R1/R2/R7 match v%0d", i), 64'(dec_match), 64'(VEC[i].m));
         chk($sformatf("R6 idx v%0d", i), 64'(dec_idx), 64'(VEC[i].idx));
         chk($sformatf("R4 mask v%0d", i), 64'(dec_port_mask), 64'(VEC[i].mask));
         chk($sformatf("R4 cpu v%0d", i), 64'(dec_to_cpu), 64'(VEC[i].cpu));
         chk($sformatf("R3/R5 drop v%0d", i), 64'(dec_drop), 64'(VEC[i].drop));
         chk($sformatf("R8 crit v%0d", i), 64'(dec_crit), 64'(VEC[i].crit));
      end

      // R10 counters after the walk
      chk("R10 cnt entry0", 64'(cnt_of(0)), 64'd1);
      chk("R10 cnt entry6 no-dest", 64'(cnt_of(6)), 64'd1);
      chk("R10 cnt entry7 no-action", 64'(cnt_of(7)), 64'd1);
      chk("R10 cnt entry9", 64'(cnt_of(9)), 64'd1);
      chk("R10 cnt entry1 untouched", 64'(cnt_of(1)), 64'd0);
      chk("R10 cnt entry8 shadowed", 64'(cnt_of(8)), 64'd0);
      send(3'd0, 1'b1, 1'b0, DA_A, 12'd100, 3'd0);
      send(3'd0, 1'b1, 1'b0, DA_A, 12'd100, 3'd0);
      chk("R10 cnt entry0 after two", 64'(cnt_of(0)), 64'd3);

      // R11 rewrite clears counter and changes actions
      load(0, 1, DA_A, 12'd100, 3'd0, 0, 1, 0, 0, 5'b00000);
      chk("R11 cnt cleared", 64'(cnt_of(0)), 64'd0);
      send(3'd0, 1'b1, 1'b0, DA_A, 12'd100, 3'd0);
      chk("R11 new action cpu", 64'(dec_to_cpu), 64'd1);
      chk("R11 new action no drop", 64'(dec_drop), 64'd0);
      chk("R11 cnt stays zero", 64'(cnt_of(0)), 64'd0);

      // R11 disable entry1 -> entry2 takes over (R6)
      load(1, 0, DA_B, 12'd100, 3'd3, 0, 1, 0, 0, 5'b00000);
      send(3'd1, 1'b1, 1'b0, DA_B, 12'd100, 3'd3);
      chk("R11 removed entry idx", 64'(dec_idx), 64'd2);
      chk("R6 next entry mask", 64'(dec_port_mask), 64'h08);
      chk("R6 next entry cpu", 64'(dec_to_cpu), 64'd0);

      // R9 idle cycle
      @(negedge clk);
      chk("R9 idle valid", 64'(dec_valid), 64'd0);
      chk("R9 idle match", 64'(dec_match), 64'd0);

      // R10 saturation on entry6
      @(negedge clk);
      frm_port = 3'd0; frm_da = DA_E; frm_vid = 12'd10; frm_pcp = 3'd1;
      port_vlan_aware = '1; port_in_bridge = '0;
      frm_valid = 1'b1;
      repeat (65540) @(negedge clk);
      frm_valid = 1'b0;
      @(negedge clk);
      chk("R10 saturated", 64'(cnt_of(6)), 64'hFFFF);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule